// File: doc/BRIEF.md
# Byte-Sliced Column Mixer

This block applies the diffusion step of a wide-state hash permutation to a single 64-bit column of eight bytes. Each output byte is a GF(2^8) weighted sum of all eight input bytes, and the weights rotate from one output byte to the next. The arithmetic uses the reduction polynomial x^8+x^4+x^3+x+1. The block does not multiply by each constant separately. It builds the result from a small set of shared XOR terms plus two doublings per byte, which keeps the logic shallow and narrow. A full state is covered by placing several copies side by side.

A parameter selects between two forms. In the registered form the result is captured in a one-entry output stage with a valid/ready handshake. In the pass-through form the path is purely combinational and the handshake signals pass straight through.

Top module: `colmix_unit`

## Requirements
- R1: Doubling a byte shifts it left by one bit, and the result is XORed with 0x1b whenever the input's bit 7 was set. For example, the single input byte 0x80 yields the output bytes 0x1b, 0xad, 0xb6, 0x9b, 0xb6, 0x36, 0x9b, 0x1b.
- R2: Output byte k equals the XOR over j of M[(j-k) mod 8]·a_j, with M = (02,02,03,04,05,03,05,07). This must hold for arbitrary columns.
- R3: Input byte a0 occupies in_col[63:56], a1 occupies [55:48], and so on down to a7 in [7:0]. Output bytes use the same order. A lone 0x01 in a0 gives 0x0207050305040302, and a lone 0x01 in a1 gives 0x0202070503050403.
- R4: An all-zero column maps to zero. A column of all 0x01 maps to all 0x03, and a column of all 0xff maps to all 0x1a.
- R5: In the registered form, a column accepted on a clock edge (in_valid and in_ready both high) appears on out_col with out_valid high right after that edge.
- R6: In the registered form, while out_valid is high and out_ready is low, out_col and out_valid hold and in_ready is low, so offered columns are not taken.
- R7: In the registered form, when the held result is consumed and a new column is offered in the same cycle, the new result replaces it with no empty cycle. With in_valid held high, results stream at one per cycle.
- R8: While rst_n is low at a clock edge, out_valid and out_col clear to zero. In the registered form in_ready is high after reset.
- R9: In the pass-through form, out_col is the mix of in_col in the same cycle, out_valid follows in_valid, and in_ready follows out_ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Input column offered |
| in_ready | output | 1 | Block can take a column this cycle |
| in_col | input | 64 | Input column, a0 in the top byte |
| out_valid | output | 1 | Result available |
| out_ready | input | 1 | Downstream takes the result this cycle |
| out_col | output | 64 | Mixed column, b0 in the top byte |

## Verification
In the registered form, draining the held result and loading a new column can happen in the same clock cycle. The bench provokes this in two ways. First, it holds in_valid high across consecutive cycles with out_ready high. Second, it releases out_ready while a column has been waiting behind a stalled result. In both cases it checks that the result after each edge is the mix of the column offered in the cycle before, with no gap and no repeat. During the stall it checks that out_col does not move and that in_ready stays low.

// File: rtl/colmix_pkg.sv
// Package colmix_pkg
// Shared widths and the byte type for the column mixer.
// Assumes eight byte lanes per column; the mixing network depends on that count.
package colmix_pkg;
    localparam int LANES  = 8;
    localparam int BYTE_W = 8;
    localparam int COL_W  = LANES * BYTE_W;
    localparam logic [BYTE_W-1:0] REDUCE = 8'h1b;

    typedef logic [BYTE_W-1:0] lane_t;
endpackage

// File: rtl/gf_dbl.sv
// Module gf_dbl
// Multiplies one byte by two in GF(2^8) with the polynomial x^8+x^4+x^3+x+1.
// Assumes nothing beyond a full byte on its input; purely combinational.
module gf_dbl
    import colmix_pkg::*;
(
    input  lane_t din,
    output lane_t dout
);
    // shift and conditionally reduce
    always_comb begin
        dout = {din[BYTE_W-2:0], 1'b0} ^ (din[BYTE_W-1] ? REDUCE : '0);
    end

    // the low bit of a doubled byte must carry the dropped top bit (R1)
    always_comb begin
        assert_dbl_lowbit_R1: assert (dout[0] == din[BYTE_W-1]);
    end
endmodule

// File: rtl/colmix_core.sv
// Module colmix_core
// Combinational column mix built from shared XOR terms and two doublings per
// byte. Assumes lane 0 sits in the top byte of the column, lane 7 at the bottom.
module colmix_core
    import colmix_pkg::*;
(
    input  logic [COL_W-1:0] col_i,
    output logic [COL_W-1:0] col_o
);
    lane_t a [LANES];
    lane_t t [LANES];
    lane_t x [LANES];
    lane_t y [LANES];
    lane_t z [LANES];
    lane_t w [LANES];
    lane_t v [LANES];

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        // unpack the lane from the column
        assign a[i] = col_i[COL_W-1-BYTE_W*i -: BYTE_W];
        // pairwise neighbour sum
        assign t[i] = a[i] ^ a[(i+1) % LANES];
        // sum of two pair terms three lanes apart
        assign x[i] = t[i] ^ t[(i+3) % LANES];
        // five-byte partial sum reused twice
        assign y[i] = t[i] ^ t[(i+2) % LANES] ^ a[(i+6) % LANES];
        // first doubling
        gf_dbl u_dbl_z (.din(x[i]), .dout(z[i]));
        // add the partial sum four lanes ahead
        assign w[i] = z[i] ^ y[(i+4) % LANES];
        // second doubling
        gf_dbl u_dbl_v (.din(w[i]), .dout(v[i]));
        // final combine and repack
        assign col_o[COL_W-1-BYTE_W*i -: BYTE_W] = v[(i+3) % LANES] ^ y[(i+4) % LANES];
    end

    // the map is linear, so zero in must give zero out (R4)
    always_comb begin
        if (col_i == '0) begin
            assert_zero_map_R4: assert (col_o == '0);
        end
    end
endmodule

// File: rtl/colmix_ostage.sv
// Module colmix_ostage
// One-entry output register with a valid/ready handshake. Loads when empty or
// when the held entry drains in the same cycle. Synchronous active-low reset.
module colmix_ostage #(
    parameter int W = 64
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    output logic         in_ready,
    input  logic [W-1:0] in_data,
    output logic         out_valid,
    input  logic         out_ready,
    output logic [W-1:0] out_data
);
    logic take;

    // accept when empty or being drained this cycle
    always_comb begin
        in_ready = !out_valid || out_ready;
        take     = in_valid && in_ready;
    end

    // hold, load or drain the single entry
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else if (take) begin
            out_valid <= 1'b1;
            out_data  <= in_data;
        end else if (out_ready) begin
            out_valid <= 1'b0;
        end
    end

    // an accepted column shows up one edge later (R5)
    assert_accept_latency_R5: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready |=> out_valid && out_data == $past(in_data));

    // a stalled result neither moves nor vanishes (R6)
    assert_stall_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_data));

    // drained with nothing offered leaves the stage empty (R7)
    assert_drain_empty_R7: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_ready && !in_valid |=> !out_valid);
endmodule

// File: rtl/colmix_unit.sv
// Module colmix_unit
// Top of the column mixer. REG_OUT = 1 registers the result behind a
// valid/ready stage; REG_OUT = 0 leaves the path combinational.
module colmix_unit
    import colmix_pkg::*;
#(
    parameter bit REG_OUT = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [COL_W-1:0] in_col,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [COL_W-1:0] out_col
);
    logic [COL_W-1:0] mixed;

    colmix_core u_core (.col_i(in_col), .col_o(mixed));

    if (REG_OUT) begin : g_reg
        colmix_ostage #(.W(COL_W)) u_ostage (
            .clk      (clk),
            .rst_n    (rst_n),
            .in_valid (in_valid),
            .in_ready (in_ready),
            .in_data  (mixed),
            .out_valid(out_valid),
            .out_ready(out_ready),
            .out_data (out_col)
        );
    end else begin : g_pass
        // straight-through handshake and data
        always_comb begin
            out_valid = in_valid;
            in_ready  = out_ready;
            out_col   = mixed;
        end

        // with no storage, acceptance and delivery coincide (R9)
        assert_same_cycle_R9: assert property (@(posedge clk) disable iff (!rst_n)
            in_valid && in_ready |-> out_valid && out_ready);
    end
endmodule

// File: tb/colmix_unit_bench.sv
module colmix_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        out_ready = 1'b1;
    logic [63:0] in_col = '0;
    logic        in_ready;
    logic        out_valid;
    logic [63:0] out_col;

    logic        p_in_valid = 1'b0;
    logic        p_out_ready = 1'b0;
    logic [63:0] p_in_col = '0;
    logic        p_in_ready;
    logic        p_out_valid;
    logic [63:0] p_out_col;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    colmix_unit #(.REG_OUT(1'b1)) u_colmix_unit (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_col(in_col), .out_valid(out_valid), .out_ready(out_ready), .out_col(out_col)
    );

    colmix_unit #(.REG_OUT(1'b0)) u_colmix_pass (
        .clk(clk), .rst_n(rst_n), .in_valid(p_in_valid), .in_ready(p_in_ready),
        .in_col(p_in_col), .out_valid(p_out_valid), .out_ready(p_out_ready), .out_col(p_out_col)
    );

    localparam logic [63:0] VIN [6] = '{
        64'h0100000000000000, 64'h8000000000000000, 64'h0001000000000000,
        64'h0000000000000000, 64'h0101010101010101, 64'hffffffffffffffff };
    localparam logic [63:0] VEXP [6] = '{
        64'h0207050305040302, 64'h1badb69bb6369b1b, 64'h0202070503050403,
        64'h0000000000000000, 64'h0303030303030303, 64'h1a1a1a1a1a1a1a1a };
    localparam logic [7:0] COEF [8] = '{8'h02, 8'h02, 8'h03, 8'h04, 8'h05, 8'h03, 8'h05, 8'h07};

    function automatic logic [7:0] gmul(input logic [7:0] a, input logic [7:0] c);
        logic [7:0] acc = '0;
        logic [7:0] p = a;
        for (int k = 0; k < 8; k++) begin
            if (c[k]) acc ^= p;
            p = p[7] ? ((p << 1) ^ 8'h1b) : (p << 1);
        end
        return acc;
    endfunction

    function automatic logic [63:0] ref_mix(input logic [63:0] col);
        logic [63:0] r = '0;
        for (int i = 0; i < 8; i++) begin
            logic [7:0] acc = '0;
            for (int j = 0; j < 8; j++)
                acc ^= gmul(col[63-8*j -: 8], COEF[(j - i + 8) % 8]);
            r[63-8*i -: 8] = acc;
        end
        return r;
    endfunction

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // present one column for one edge, then sample after it
    task automatic push(input logic [63:0] col);
        @(negedge clk);
        in_valid = 1'b1;
        in_col = col;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    initial begin
        // reset state (R8)
        in_valid = 1'b1;
        in_col = 64'hdeadbeefdeadbeef;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(out_valid == 1'b0, "R8 valid after reset", {63'd0, out_valid}, 64'd0);
        check(out_col == '0, "R8 data after reset", out_col, 64'd0);
        check(in_ready == 1'b1, "R8 ready after reset", {63'd0, in_ready}, 64'd1);
        in_valid = 1'b0;
        rst_n = 1'b1;

        // table vectors: R1 R2 R3 R4, plus R5 latency
        for (int n = 0; n < 6; n++) begin
            push(VIN[n]);
            check(out_valid, "R5 valid one edge after accept", {63'd0, out_valid}, 64'd1);
            check(out_col == VEXP[n], "R1 R2 R3 R4 table vector", out_col, VEXP[n]);
        end

        // random columns against the reference product (R2)
        for (int n = 0; n < 40; n++) begin
            logic [63:0] c = {$urandom(), $urandom()};
            push(c);
            check(out_col == ref_mix(c), "R2 random column", out_col, ref_mix(c));
        end

        // drain with nothing offered
        @(negedge clk);
        check(!out_valid, "R7 empty after drain", {63'd0, out_valid}, 64'd0);

        // back-to-back streaming (R7)
        @(negedge clk);
        for (int n = 0; n < 4; n++) begin
            logic [63:0] c = {$urandom(), $urandom()};
            in_valid = 1'b1;
            in_col = c;
            @(negedge clk);
            check(out_valid && out_col == ref_mix(c), "R7 stream no bubble", out_col, ref_mix(c));
        end
        in_valid = 1'b0;

        // stall behind a held result (R6), then release into a same-cycle swap (R7)
        begin
            logic [63:0] ca = 64'h0123456789abcdef;
            logic [63:0] cb = 64'hfedcba9876543210;
            push(ca);
            out_ready = 1'b0;
            in_valid = 1'b1;
            in_col = cb;
            for (int n = 0; n < 3; n++) begin
                #1;
                check(!in_ready, "R6 not ready while stalled", {63'd0, in_ready}, 64'd0);
                @(negedge clk);
                check(out_valid && out_col == ref_mix(ca), "R6 held under stall", out_col, ref_mix(ca));
            end
            out_ready = 1'b1;
            @(negedge clk);
            in_valid = 1'b0;
            check(out_valid && out_col == ref_mix(cb), "R7 swap on release", out_col, ref_mix(cb));
        end

        // pass-through variant (R9)
        for (int n = 0; n < 5; n++) begin
            logic [63:0] c = {$urandom(), $urandom()};
            @(negedge clk);
            p_in_col = c;
            p_in_valid = n[0];
            p_out_ready = !n[0];
            #1;
            check(p_out_col == ref_mix(c), "R9 same-cycle data", p_out_col, ref_mix(c));
            check(p_out_valid == n[0] && p_in_ready == !n[0], "R9 handshake follows",
                  {62'd0, p_out_valid, p_in_ready}, {62'd0, n[0], !n[0]});
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=%h expected=%h", 64'd0, 64'd1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule